// File: doc/BRIEF.md
# SPI Register Access Bridge

This block is an SPI target (mode 0, one active-low chip select) that turns framed SPI traffic into accesses on a simple internal 32-bit register bus. Every frame begins with a 32-bit header word that carries an opcode, a 16-bit byte address and a burst word count. Within the same chip-select assertion the controller then sends the data words of a write, or clocks out the data words of a read. Each data word moves the byte address up by 4, so one frame can cover a run of consecutive registers.

The byte address is sorted into one of three windows: device configuration and interrupt registers, CAN controller registers, and message RAM. The window code is shown on the bus next to the address, so the register file behind the bridge can route the access. Addresses past the RAM window are rejected. The bus itself is a request/acknowledge handshake. A request stays asserted until it is acknowledged.

The SPI pins are sampled by the system clock through synchronizers, so SCLK must be several times slower than the system clock. For a read, the next word is fetched while the current word is still shifting out. The first word of a read must be returned by the bus within about half an SCLK period after the header ends.

Top module: `spi_reg_bridge`

## Requirements
- R1: SPI words are 32 bits, sent MSB first in mode 0. The target samples MOSI on the rising SCLK edge and changes MISO after the falling edge.
- R2: The header word carries the opcode in bits 31:24, the byte address in bits 23:8 and the data word count in bits 7:0.
- R3: Opcode 0x61 is a write. Each of the next `count` received words is written to the bus, at the header address for the first word and at +4 for each word after it.
- R4: Opcode 0x41 is a read. MISO returns `count` words that start in the word slot right after the header, with no idle slot between words. The words are read from the header address and the addresses +4 above it.
- R5: The bus window code is 0 for addresses 0x0000–0x0FFF (device), 1 for 0x1000–0x7FFF (controller) and 2 for 0x8000–0x8FFF (message RAM).
- R6: An address at or above 0x9000, including one reached by the increment during a burst, makes no bus access and sets the error flag. Such a write word is discarded, and such a read word returns zero.
- R7: An opcode other than 0x41 or 0x61 sets the error flag, makes no bus access and returns zero words.
- R8: Words past the header count make no bus access and do not set the error flag. During a read they return zero.
- R9: Raising chip select in the middle of a word aborts the frame: the partial word makes no bus access. The next frame is decoded from a fresh header.
- R10: A bus request keeps its address, direction and write data stable until it is acknowledged.
- R11: After reset, MISO, the bus request and the error flag are 0. Once set, the error flag stays set until reset.
- R12: While chip select is high, MISO is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (idle low) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from controller |
| spi_miso | output | 1 | Serial data to controller |
| bus_req | output | 1 | Register bus request, held until acknowledged |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Byte address of the access |
| bus_region | output | 2 | Window code: 0 device, 1 controller, 2 message RAM |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |
| err_flag | output | 1 | Sticky error flag |

## Verification
The hardest cases to reach are the ones where chip select does not line up with word boundaries. These are a frame cut off a few bits into its second data word, and a burst whose address increment crosses out of the RAM window between two words. The bench drives SCLK, MOSI and chip select bit by bit from a task, so it can stop a frame after any number of bits. It places read and write bursts on window edges so that the crossing falls inside one frame. A bus responder with a selectable acknowledge delay stretches requests over several cycles, which exposes any address or data change while a request is still waiting.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int OP_W   = 8;
  localparam int BIT_CNT_W = $clog2(WORD_W);
  localparam int ADDR_STEP = WORD_W / 8;

  localparam logic [OP_W-1:0] OP_WRITE = 8'h61;
  localparam logic [OP_W-1:0] OP_READ  = 8'h41;

  typedef enum logic [1:0] {
    WIN_DEV  = 2'd0,
    WIN_CTL  = 2'd1,
    WIN_RAM  = 2'd2,
    WIN_NONE = 2'd3
  } window_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  count;
  } header_t;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_FETCH,
    ST_WAIT,
    ST_BUS,
    ST_DRAIN
  } ctrl_state_e;
endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
  parameter int STAGES = 2,
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] stage_d;
    if (i == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_rest
      assign stage_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= RST_VAL;
      else        stage_q[i] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_bridge_shifter.sv
module spi_bridge_shifter
  import spi_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [WORD_W-1:0] tx_word,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              tx_load,
  output logic              miso
);
  logic                 sclk_d;
  logic [BIT_CNT_W-1:0] cnt_q, cnt_n;
  logic [WORD_W-1:0]    rx_q, rx_n;
  logic [WORD_W-1:0]    tx_q, tx_n;
  logic [WORD_W-1:0]    word_q, word_n;
  logic                 done_q, done_n;
  logic                 pend_q, pend_n;
  logic                 rise, fall, active;

  assign rise   = sclk_s & ~sclk_d;
  assign fall   = ~sclk_s & sclk_d;
  assign active = ~cs_n_s;

  always_comb begin
    cnt_n  = cnt_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    word_n = word_q;
    done_n = 1'b0;
    pend_n = pend_q;
    if (!active) begin
      cnt_n  = '0;
      tx_n   = '0;
      pend_n = 1'b0;
    end else begin
      if (rise) begin
        rx_n  = {rx_q[WORD_W-2:0], mosi_s};
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == BIT_CNT_W'(WORD_W - 1)) begin
          done_n = 1'b1;
          word_n = {rx_q[WORD_W-2:0], mosi_s};
          pend_n = 1'b1;
        end
      end
      if (fall) begin
        if (pend_q) begin
          tx_n   = tx_word;
          pend_n = 1'b0;
        end else begin
          tx_n = {tx_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      word_q <= '0;
      done_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cnt_q  <= cnt_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      word_q <= word_n;
      done_q <= done_n;
      pend_q <= pend_n;
    end
  end

  assign word_done = done_q;
  assign rx_word   = word_q;
  assign tx_load   = active & fall & pend_q;
  assign miso      = tx_q[WORD_W-1];
endmodule

// File: rtl/spi_bridge_decode.sv
module spi_bridge_decode
  import spi_bridge_pkg::*;
#(
  parameter int CTL_BASE = 32'h1000,
  parameter int RAM_BASE = 32'h8000,
  parameter int RAM_END  = 32'h9000
) (
  input  logic [ADDR_W:0] addr,
  output window_e         window
);
  localparam int FULL_W = ADDR_W + 1;

  always_comb begin
    if (addr >= FULL_W'(RAM_END))       window = WIN_NONE;
    else if (addr >= FULL_W'(RAM_BASE)) window = WIN_RAM;
    else if (addr >= FULL_W'(CTL_BASE)) window = WIN_CTL;
    else                                window = WIN_DEV;
  end
endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl
  import spi_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              word_done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              tx_load,
  input  window_e           window,
  input  logic              bus_ack,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic [ADDR_W:0]   cur_addr,
  output logic [WORD_W-1:0] next_word,
  output logic              bus_req,
  output logic              bus_write,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              err
);
  localparam int FULL_W = ADDR_W + 1;

  ctrl_state_e       st_q, st_n;
  logic              rd_q, rd_n;
  logic [ADDR_W:0]   addr_q, addr_n;
  logic [CNT_W-1:0]  rem_q, rem_n;
  logic [WORD_W-1:0] wdata_q, wdata_n;
  logic [WORD_W-1:0] nxt_q, nxt_n;
  logic              err_q, err_n;
  header_t           hdr;
  logic [ADDR_W:0]   addr_inc;
  logic              last_word;

  assign hdr       = header_t'(rx_word);
  assign addr_inc  = addr_q + FULL_W'(ADDR_STEP);
  assign last_word = (rem_q == CNT_W'(1));

  always_comb begin
    st_n    = st_q;
    rd_n    = rd_q;
    addr_n  = addr_q;
    rem_n   = rem_q;
    wdata_n = wdata_q;
    nxt_n   = nxt_q;
    err_n   = err_q;
    if (cs_idle && st_q != ST_BUS) begin
      st_n  = ST_HDR;
      nxt_n = '0;
    end else begin
      case (st_q)
        ST_HDR: begin
          if (word_done) begin
            addr_n = {1'b0, hdr.addr};
            rem_n  = hdr.count;
            nxt_n  = '0;
            if (hdr.op == OP_WRITE) begin
              rd_n = 1'b0;
              st_n = (hdr.count == '0) ? ST_DRAIN : ST_WAIT;
            end else if (hdr.op == OP_READ) begin
              rd_n = 1'b1;
              st_n = (hdr.count == '0) ? ST_DRAIN : ST_FETCH;
            end else begin
              err_n = 1'b1;
              st_n  = ST_DRAIN;
            end
          end
        end
        ST_FETCH: begin
          if (window == WIN_NONE) begin
            err_n  = 1'b1;
            nxt_n  = '0;
            addr_n = addr_inc;
            rem_n  = rem_q - 1'b1;
            st_n   = ST_WAIT;
          end else begin
            st_n = ST_BUS;
          end
        end
        ST_WAIT: begin
          if (rd_q) begin
            if (tx_load) begin
              nxt_n = '0;
              st_n  = (rem_q != '0) ? ST_FETCH : ST_DRAIN;
            end
          end else if (word_done) begin
            if (window == WIN_NONE) begin
              err_n  = 1'b1;
              addr_n = addr_inc;
              rem_n  = rem_q - 1'b1;
              st_n   = last_word ? ST_DRAIN : ST_WAIT;
            end else begin
              wdata_n = rx_word;
              st_n    = ST_BUS;
            end
          end
        end
        ST_BUS: begin
          if (bus_ack) begin
            addr_n = addr_inc;
            rem_n  = rem_q - 1'b1;
            if (rd_q) begin
              nxt_n = cs_idle ? '0 : bus_rdata;
              st_n  = cs_idle ? ST_HDR : ST_WAIT;
            end else begin
              st_n = cs_idle ? ST_HDR : (last_word ? ST_DRAIN : ST_WAIT);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HDR;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      wdata_q <= '0;
      nxt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      rd_q    <= rd_n;
      addr_q  <= addr_n;
      rem_q   <= rem_n;
      wdata_q <= wdata_n;
      nxt_q   <= nxt_n;
      err_q   <= err_n;
    end
  end

  assign cur_addr  = addr_q;
  assign next_word = nxt_q;
  assign bus_req   = (st_q == ST_BUS);
  assign bus_write = ~rd_q;
  assign bus_wdata = wdata_q;
  assign err       = err_q;
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import spi_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CTL_BASE    = 32'h1000,
  parameter int RAM_BASE    = 32'h8000,
  parameter int RAM_END     = 32'h9000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        bus_req,
  output logic        bus_write,
  output logic [15:0] bus_addr,
  output logic [1:0]  bus_region,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ack,
  output logic        err_flag
);
  logic              rst_n_s;
  logic [2:0]        pins_s;
  logic              sclk_s, cs_n_s, mosi_s;
  logic              word_done, tx_load;
  logic [WORD_W-1:0] rx_word, next_word;
  logic [ADDR_W:0]   cur_addr;
  window_e           window;

  spi_bridge_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  spi_bridge_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_pin_sync (
    .clk(clk), .rst_n(rst_n_s), .d({spi_sclk, spi_cs_n, spi_mosi}), .q(pins_s)
  );

  assign {sclk_s, cs_n_s, mosi_s} = pins_s;

  spi_bridge_shifter u_shift (
    .clk(clk), .rst_n(rst_n_s),
    .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .tx_word(next_word), .word_done(word_done), .rx_word(rx_word),
    .tx_load(tx_load), .miso(spi_miso)
  );

  spi_bridge_decode #(.CTL_BASE(CTL_BASE), .RAM_BASE(RAM_BASE), .RAM_END(RAM_END)) u_dec (
    .addr(cur_addr), .window(window)
  );

  spi_bridge_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .cs_idle(cs_n_s),
    .word_done(word_done), .rx_word(rx_word), .tx_load(tx_load),
    .window(window), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .cur_addr(cur_addr), .next_word(next_word),
    .bus_req(bus_req), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .err(err_flag)
  );

  assign bus_addr   = cur_addr[ADDR_W-1:0];
  assign bus_region = window;
endmodule

// File: rtl/spi_reg_bridge_chk.sv
module spi_reg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_cs_n,
  input logic        spi_miso,
  input logic        bus_req,
  input logic        bus_write,
  input logic [15:0] bus_addr,
  input logic [1:0]  bus_region,
  input logic [31:0] bus_wdata,
  input logic        bus_ack,
  input logic        err_flag
);
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata));

  assert_no_invalid_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_region != 2'd3);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_miso_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) |-> !spi_miso);
endmodule

bind spi_reg_bridge spi_reg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_region(bus_region), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .err_flag(err_flag)
);

// File: tb/tb_spi_reg_bridge.sv
`timescale 1ns/1ps
module tb_spi_reg_bridge;
  localparam real HALF = 80.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic bus_req, bus_write, err_flag;
  logic [15:0] bus_addr;
  logic [1:0]  bus_region;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ack = 1'b0;

  always #2.5 clk = ~clk;

  spi_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bus_req(bus_req),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_region(bus_region),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .err_flag(err_flag)
  );

  int errors = 0, checks = 0;
  int ack_delay = 0, wait_cnt = 0, hold_viol = 0;
  int n_wr = 0, n_rd = 0;
  logic [15:0] held_addr;
  logic [31:0] held_data;
  logic [15:0] wlog_addr [16];
  logic [31:0] wlog_data [16];
  logic [1:0]  wlog_reg  [16];
  logic [1:0]  last_rd_reg;
  logic [31:0] rbuf [8];

  function automatic logic [31:0] pat(input logic [15:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  // Bus responder, driven away from the active edge
  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (wait_cnt == 0) begin
        held_addr = bus_addr; held_data = bus_wdata;
      end else if (bus_addr != held_addr || (bus_write && bus_wdata != held_data)) begin
        hold_viol++;
      end
      if (wait_cnt >= ack_delay) begin
        bus_ack = 1'b1;
        wait_cnt = 0;
        if (bus_write) begin
          if (n_wr < 16) begin
            wlog_addr[n_wr] = bus_addr; wlog_data[n_wr] = bus_wdata; wlog_reg[n_wr] = bus_region;
          end
          n_wr++;
        end else begin
          bus_rdata = pat(bus_addr);
          last_rd_reg = bus_region;
          n_rd++;
        end
      end else wait_cnt++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    spi_cs_n = 1'b1; spi_sclk = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic spi_word(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = '0;
    for (int b = 31; b > 31 - nbits; b--) begin
      spi_mosi = tx[b];
      #(HALF);
      rx[b] = spi_miso;
      spi_sclk = 1'b1;
      #(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic frame_begin(); spi_cs_n = 1'b0; endtask
  task automatic frame_end(); #(HALF); spi_cs_n = 1'b1; #(4*HALF); endtask

  // Sends a header, then nwords data words (write data or dummy), capturing MISO
  task automatic frame(input logic [7:0] op, input logic [15:0] a, input logic [7:0] cnt,
                       input int nwords, input logic [31:0] dbase);
    logic [31:0] rx;
    frame_begin();
    spi_word({op, a, cnt}, 32, rx);
    for (int k = 0; k < nwords; k++) begin
      spi_word(dbase + 32'(k), 32, rx);
      if (k < 8) rbuf[k] = rx;
    end
    frame_end();
  endtask

  task automatic t_reset();
    check("R11 reset miso", {31'd0, spi_miso}, 32'd0);
    check("R11 reset bus_req", {31'd0, bus_req}, 32'd0);
    check("R11 reset err", {31'd0, err_flag}, 32'd0);
  endtask

  task automatic t_write_burst();
    int n0 = n_wr;
    frame(8'h61, 16'h0804, 8'd3, 3, 32'h1111_0000);
    check("R3 write count", 32'(n_wr - n0), 32'd3);
    for (int k = 0; k < 3; k++) begin
      check("R2 R3 write addr", {16'd0, wlog_addr[n0+k]}, 32'h0804 + 32'(4*k));
      check("R1 R3 write data", wlog_data[n0+k], 32'h1111_0000 + 32'(k));
      check("R5 window dev", {30'd0, wlog_reg[n0+k]}, 32'd0);
    end
  endtask

  task automatic t_read_burst();
    int n0 = n_rd;
    frame(8'h41, 16'h1000, 8'd4, 4, 32'h0);
    check("R4 read count", 32'(n_rd - n0), 32'd4);
    for (int k = 0; k < 4; k++)
      check("R1 R4 read word", rbuf[k], pat(16'h1000 + 16'(4*k)));
    check("R5 window ctl", {30'd0, last_rd_reg}, 32'd1);
    check("R12 miso idle", {31'd0, spi_miso}, 32'd0);
  endtask

  task automatic t_ram_read();
    frame(8'h41, 16'h8000, 8'd2, 2, 32'h0);
    check("R4 ram word0", rbuf[0], pat(16'h8000));
    check("R4 ram word1", rbuf[1], pat(16'h8004));
    check("R5 window ram", {30'd0, last_rd_reg}, 32'd2);
  endtask

  task automatic t_beyond_count();
    int w0 = n_wr, r0 = n_rd;
    frame(8'h61, 16'h2000, 8'd1, 3, 32'hAB00_0000);
    check("R8 extra writes ignored", 32'(n_wr - w0), 32'd1);
    check("R8 write data", wlog_data[w0], 32'hAB00_0000);
    frame(8'h41, 16'h3000, 8'd1, 3, 32'h0);
    check("R8 read count", 32'(n_rd - r0), 32'd1);
    check("R8 read word0", rbuf[0], pat(16'h3000));
    check("R8 extra word1 zero", rbuf[1], 32'd0);
    check("R8 extra word2 zero", rbuf[2], 32'd0);
    check("R8 no error", {31'd0, err_flag}, 32'd0);
  endtask

  task automatic t_slow_bus();
    int w0 = n_wr;
    ack_delay = 5;
    hold_viol = 0;
    frame(8'h61, 16'h1100, 8'd2, 2, 32'h5500_0010);
    ack_delay = 0;
    check("R10 request held stable", 32'(hold_viol), 32'd0);
    check("R10 slow write count", 32'(n_wr - w0), 32'd2);
    check("R10 slow write data", wlog_data[w0+1], 32'h5500_0011);
  endtask

  task automatic t_abort();
    logic [31:0] rx;
    int w0 = n_wr;
    frame_begin();
    spi_word({8'h61, 16'h1200, 8'd2}, 32, rx);
    spi_word(32'hC0C0_0001, 32, rx);
    spi_word(32'hC0C0_0002, 7, rx);
    frame_end();
    check("R9 partial word dropped", 32'(n_wr - w0), 32'd1);
    frame(8'h61, 16'h1300, 8'd1, 1, 32'hD0D0_0003);
    check("R9 fresh header count", 32'(n_wr - w0), 32'd2);
    check("R9 fresh header addr", {16'd0, wlog_addr[w0+1]}, 32'h1300);
    check("R9 fresh header data", wlog_data[w0+1], 32'hD0D0_0003);
    check("R9 no error", {31'd0, err_flag}, 32'd0);
  endtask

  task automatic t_cross_ram();
    int r0 = n_rd, w0 = n_wr;
    frame(8'h41, 16'h8FFC, 8'd2, 2, 32'h0);
    check("R6 last ram word", rbuf[0], pat(16'h8FFC));
    check("R6 crossed word zero", rbuf[1], 32'd0);
    check("R6 one bus read", 32'(n_rd - r0), 32'd1);
    check("R6 error set", {31'd0, err_flag}, 32'd1);
    frame(8'h61, 16'h0810, 8'd1, 1, 32'h7777_0000);
    check("R11 error sticky", {31'd0, err_flag}, 32'd1);
    check("R11 write after error", 32'(n_wr - w0), 32'd1);
    apply_reset();
    check("R11 error cleared by reset", {31'd0, err_flag}, 32'd0);
  endtask

  task automatic t_bad_op();
    int r0 = n_rd, w0 = n_wr;
    frame(8'h52, 16'h1000, 8'd2, 2, 32'hFFFF_FFFF);
    check("R7 no bus access", 32'((n_rd - r0) + (n_wr - w0)), 32'd0);
    check("R7 word0 zero", rbuf[0], 32'd0);
    check("R7 word1 zero", rbuf[1], 32'd0);
    check("R7 error set", {31'd0, err_flag}, 32'd1);
    apply_reset();
  endtask

  task automatic t_write_invalid();
    int w0 = n_wr;
    frame(8'h61, 16'h9000, 8'd2, 2, 32'hEEEE_0000);
    check("R6 write discarded", 32'(n_wr - w0), 32'd0);
    check("R6 error on write", {31'd0, err_flag}, 32'd1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #900_000;
    errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    apply_reset();
    t_reset();
    t_write_burst();
    t_read_burst();
    t_ram_read();
    t_beyond_count();
    t_slow_bus();
    t_abort();
    t_cross_ram();
    t_bad_op();
    t_write_invalid();
    finish_run();
  end
endmodule